// File: doc/BRIEF.md
# Keypad Matrix Scanner with Digit Refresh Controller

This block handles a key matrix and a multiplexed digit display on behalf of a host. It drives a scan row index to an 8 by 8 key matrix and samples the eight return lines for that row. A key that reads pressed on two consecutive visits to its row is accepted, and its 6-bit code is queued in an eight-entry first-in first-out queue. In parallel, a digit counter steps through 8 or 16 display positions and presents the byte held for each position in a small internal display memory.

The host reaches the block through a byte-wide register port made of chip select, read strobe, write strobe and one address line. With the address line high, a write is a command and a read returns status. With it low, reads and writes move data. Every cycle with chip select and a strobe high counts as one access. The top three bits of a command byte pick one of eight operations, and the lower five bits carry that operation's operands. An interrupt line tells the host that key codes are waiting.

Top module: `kdc_ctrl`

## Requirements
- R1: After reset, irq is low, scan_row is 0, digit_sel is 0, seg is 0x00, and the status byte reads 0x00.
- R2: A key that reads pressed on two consecutive scans of its row queues exactly one code {row[2:0], col[2:0]}. A press seen on only one scan queues nothing, and a release queues nothing.
- R3: The queue holds 8 codes in arrival order. A further accepted key is dropped and sets the sticky overrun flag, which is status bit 7.
- R4: A data read while the queue is selected and empty returns 0x00 and sets the underrun flag, which is status bit 6.
- R5: irq is high exactly when the queue is non-empty and no hold is pending. A data read that takes a code from the queue sets the hold. The command 111xxxxx releases the hold.
- R6: The command 001PPPPP makes scan_row and digit_sel advance once every P+1 clock cycles. The reset value of P is 31.
- R7: The command 000DDMMM sets the modes. Bit 3 selects 16 digits when 1 and 8 digits when 0. Bit 4 reverses the digit order, so that position d shows entry (last - d). Bit 0 stops new keys from being queued.
- R8: The commands 100IAAAA and 011IAAAA load the display address AAAA. 011 also selects display data for reads, and 010xxxxx selects the queue. When I (bit 4) is 1, each display data write or read advances the address by one.
- R9: The command 101xWVBC controls nibbles. W inhibits writes to the upper nibble and V inhibits writes to the lower nibble. B blanks the upper nibble of seg and C blanks the lower nibble.
- R10: The command 110xxxDF clears all display entries to 0x00 when D is 1. When F is 1 it empties the queue and clears the overrun, underrun and hold flags.
- R11: A command-side read returns the status byte {overrun, underrun, hold, 0, count[3:0]}.
- R12: When several new keys in one row become stable in the same scan, the lowest column is queued first. Each further column is queued on a following scan of that row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select for host access |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| a0 | input | 1 | 1 = command/status, 0 = data |
| din | input | 8 | Host write byte |
| dout | output | 8 | Registered host read byte |
| irq | output | 1 | Key data waiting |
| scan_row | output | 3 | Row currently being scanned |
| ret_lines | input | 8 | Return lines of the scanned row, 1 = pressed |
| digit_sel | output | 4 | Display position being refreshed |
| seg | output | 8 | Byte shown at digit_sel |

## Verification
The hardest state to reach is a full queue with a ninth key accepted behind it. Reaching it needs nine keys that each pass the two-scan rule. The bench models the key matrix as a table that follows scan_row. It presses keys one at a time, holds each long enough for two scans, and drops from the expected queue any code that arrives while the model count is already eight. The same matrix model also produces the same-row pairs and the one-scan bounce.

// File: rtl/kdc_pkg.sv
package kdc_pkg;
  typedef enum logic [2:0] {
    OP_MODE    = 3'd0,
    OP_CLOCK   = 3'd1,
    OP_RDFIFO  = 3'd2,
    OP_RDDISP  = 3'd3,
    OP_WRDISP  = 3'd4,
    OP_NIBBLE  = 3'd5,
    OP_CLEAR   = 3'd6,
    OP_EOI     = 3'd7
  } op_e;
endpackage

// File: rtl/kdc_fifo.sv
module kdc_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 6,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            push,
  input  logic            pop,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    head,
  output logic [CNTW-1:0] count,
  output logic            empty,
  output logic            full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CNTW'(do_push) - CNTW'(do_pop);
    end
  end
endmodule

// File: rtl/kdc_keyscan.sv
module kdc_keyscan #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int KW  = RW + CW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            en,
  input  logic [COLS-1:0] ret,
  output logic [RW-1:0]   row,
  output logic            push,
  output logic [KW-1:0]   code
);
  logic [COLS-1:0] prev_q [ROWS];
  logic [COLS-1:0] acc_q  [ROWS];
  logic [COLS-1:0] stable, chg, rel, prs, pick;
  logic [CW-1:0]   col;

  always_comb begin
    stable = ~(ret ^ prev_q[row]);
    chg    = stable & (ret ^ acc_q[row]);
    rel    = chg & ~ret;
    prs    = chg & ret & {COLS{en}};
    pick   = prs & (~prs + 1'b1);
    col    = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (prs[i]) col = CW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row  <= '0;
      push <= 1'b0;
      code <= '0;
      for (int r = 0; r < ROWS; r++) begin
        prev_q[r] <= '0;
        acc_q[r]  <= '0;
      end
    end else begin
      push <= 1'b0;
      if (tick) begin
        prev_q[row] <= ret;
        acc_q[row]  <= (acc_q[row] & ~rel) | pick;
        push        <= |prs;
        code        <= {row, col};
        row         <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kdc_display.sv
module kdc_display #(
  parameter int DIGITS = 16,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DIGITS),
  localparam int HW    = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    inh,
  output logic [DW-1:0] rdata,
  input  logic          wide,
  input  logic          rev,
  input  logic [1:0]    blank,
  output logic [AW-1:0] digit,
  output logic [DW-1:0] seg
);
  logic [DW-1:0] mem [DIGITS];
  logic [DW-1:0] keep, bmask, merged;
  logic [AW-1:0] last, dn, idx;

  assign rdata  = mem[addr];
  assign keep   = {{HW{inh[1]}}, {HW{inh[0]}}};
  assign bmask  = ~{{HW{blank[1]}}, {HW{blank[0]}}};
  assign merged = (mem[addr] & keep) | (wdata & ~keep);
  assign last   = wide ? AW'(DIGITS - 1) : AW'(DIGITS / 2 - 1);
  assign dn     = (digit >= last) ? '0 : digit + 1'b1;
  assign idx    = rev ? last - dn : dn;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DIGITS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      digit <= '0;
      seg   <= '0;
    end else if (tick) begin
      digit <= dn;
      seg   <= mem[idx] & bmask;
    end
  end
endmodule

// File: rtl/kdc_ctrl.sv
module kdc_ctrl
  import kdc_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int DEPTH  = 8,
  parameter int DIGITS = 16,
  parameter int DW     = 8,
  parameter int PRE_W  = 5,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int KW    = RW + CW,
  localparam int AW    = $clog2(DIGITS),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic            rd,
  input  logic            wr,
  input  logic            a0,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic            irq,
  output logic [RW-1:0]   scan_row,
  input  logic [COLS-1:0] ret_lines,
  output logic [AW-1:0]   digit_sel,
  output logic [DW-1:0]   seg
);
  op_e             op;
  logic            cmd_wr, dat_wr, cmd_rd, dat_rd;
  logic            tick, clr_fifo, clr_disp, fifo_pop;
  logic [PRE_W-1:0] pre_lim, pre_cnt;
  logic            wide, rev, kb_off, sel_fifo, ai;
  logic [AW-1:0]   ptr;
  logic [1:0]      inh, blank;
  logic            over, under, hold;
  logic            key_push;
  logic [KW-1:0]   key_code, fifo_head;
  logic [CNTW-1:0] fifo_cnt;
  logic            fifo_empty, fifo_full;
  logic [DW-1:0]   disp_rd;

  assign op       = op_e'(din[7:5]);
  assign cmd_wr   = cs & wr & a0;
  assign dat_wr   = cs & wr & ~a0;
  assign cmd_rd   = cs & rd & a0;
  assign dat_rd   = cs & rd & ~a0;
  assign tick     = (pre_cnt == pre_lim);
  assign clr_fifo = cmd_wr && (op == OP_CLEAR) && din[0];
  assign clr_disp = cmd_wr && (op == OP_CLEAR) && din[1];
  assign fifo_pop = dat_rd & sel_fifo & ~fifo_empty;
  assign irq      = ~fifo_empty & ~hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_lim <= '1;
      pre_cnt <= '0;
    end else if (cmd_wr && op == OP_CLOCK) begin
      pre_lim <= din[PRE_W-1:0];
      pre_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide <= 1'b0; rev <= 1'b0; kb_off <= 1'b0;
      sel_fifo <= 1'b1; ai <= 1'b0; ptr <= '0;
      inh <= '0; blank <= '0;
      over <= 1'b0; under <= 1'b0; hold <= 1'b0;
      dout <= '0;
    end else begin
      if (cmd_wr) begin
        case (op)
          OP_MODE:   begin rev <= din[4]; wide <= din[3]; kb_off <= din[0]; end
          OP_RDFIFO: sel_fifo <= 1'b1;
          OP_RDDISP: begin sel_fifo <= 1'b0; ai <= din[4]; ptr <= din[AW-1:0]; end
          OP_WRDISP: begin ai <= din[4]; ptr <= din[AW-1:0]; end
          OP_NIBBLE: begin inh <= din[3:2]; blank <= din[1:0]; end
          OP_CLEAR:  if (din[0]) begin over <= 1'b0; under <= 1'b0; hold <= 1'b0; end
          OP_EOI:    hold <= 1'b0;
          default:   ;
        endcase
      end
      if (key_push && fifo_full && !clr_fifo) over <= 1'b1;
      if (dat_wr && ai) ptr <= ptr + 1'b1;
      if (dat_rd) begin
        if (sel_fifo) begin
          if (fifo_empty) begin
            under <= 1'b1;
            dout  <= '0;
          end else begin
            hold <= 1'b1;
            dout <= 8'(fifo_head);
          end
        end else begin
          dout <= 8'(disp_rd);
          if (ai) ptr <= ptr + 1'b1;
        end
      end
      if (cmd_rd) dout <= {over, under, hold, 1'b0, 4'(fifo_cnt)};
    end
  end

  kdc_keyscan #(.ROWS(ROWS), .COLS(COLS)) i_scan (
    .clk(clk), .rst(rst), .tick(tick), .en(~kb_off), .ret(ret_lines),
    .row(scan_row), .push(key_push), .code(key_code)
  );

  kdc_fifo #(.DEPTH(DEPTH), .W(KW)) i_fifo (
    .clk(clk), .rst(rst), .clr(clr_fifo), .push(key_push), .pop(fifo_pop),
    .wdata(key_code), .head(fifo_head), .count(fifo_cnt),
    .empty(fifo_empty), .full(fifo_full)
  );

  kdc_display #(.DIGITS(DIGITS), .DW(DW)) i_disp (
    .clk(clk), .rst(rst), .tick(tick), .clr(clr_disp), .we(dat_wr),
    .addr(ptr), .wdata(din[DW-1:0]), .inh(inh), .rdata(disp_rd),
    .wide(wide), .rev(rev), .blank(blank), .digit(digit_sel), .seg(seg)
  );
endmodule

// File: rtl/kdc_checker.sv
module kdc_checker #(
  parameter int DEPTH = 8,
  parameter int RW    = 3,
  parameter int CNTW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_wr,
  input logic [2:0]      op_bits,
  input logic            clr_bit,
  input logic            irq,
  input logic [RW-1:0]   scan_row,
  input logic            tick,
  input logic [CNTW-1:0] fifo_cnt
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNTW'(DEPTH)); // R3
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    irq |-> (fifo_cnt != '0)); // R5
  AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && op_bits == 3'b111) |=> (irq == (fifo_cnt != '0))); // R5
  AST_CLEAR_QUEUE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && op_bits == 3'b110 && clr_bit) |=> (fifo_cnt == '0)); // R10
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(scan_row)); // R6
endmodule

bind kdc_ctrl kdc_checker #(.DEPTH(DEPTH), .RW(RW), .CNTW(CNTW)) i_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .op_bits(din[7:5]), .clr_bit(din[0]),
  .irq(irq), .scan_row(scan_row), .tick(tick), .fifo_cnt(fifo_cnt)
);

// File: tb/test_kdc_ctrl.sv
module test_kdc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       irq;
  logic [2:0] scan_row;
  logic [7:0] ret_lines;
  logic [3:0] digit_sel;
  logic [7:0] seg;
  logic [7:0] keymat [8];
  logic [7:0] exp_q [$];
  int         model_cnt = 0;
  int         total = 0;
  int         fails = 0;

  always #2 clk = ~clk;

  always_comb ret_lines = keymat[scan_row];

  kdc_ctrl i_kdc_ctrl (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .a0(a0), .din(din),
    .dout(dout), .irq(irq), .scan_row(scan_row), .ret_lines(ret_lines),
    .digit_sel(digit_sel), .seg(seg)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic a, input logic w, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cs = 1'b1; a0 = a; wr = w; rd = ~w; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; rd = 1'b0;
    q = dout;
  endtask

  task automatic cmd(input logic [7:0] d);
    logic [7:0] q;
    bus(1'b1, 1'b1, d, q);
  endtask

  task automatic wdat(input logic [7:0] d);
    logic [7:0] q;
    bus(1'b0, 1'b1, d, q);
  endtask

  task automatic rdat(output logic [7:0] q);
    bus(1'b0, 1'b0, 8'h00, q);
  endtask

  task automatic rstat(output logic [7:0] q);
    bus(1'b1, 1'b0, 8'h00, q);
  endtask

  // driver: press a key and record the code the queue should receive
  task automatic press(input int r, input int c);
    keymat[r][c] = 1'b1;
    if (model_cnt < 8) begin
      exp_q.push_back({2'b00, 3'(r), 3'(c)});
      model_cnt++;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic release_all();
    for (int r = 0; r < 8; r++) keymat[r] = 8'h00;
    repeat (40) @(negedge clk);
  endtask

  // monitor: read one code and compare with the oldest expected one
  task automatic take_one(input string req);
    logic [7:0] q;
    logic [7:0] e;
    rdat(q);
    e = exp_q.pop_front();
    model_cnt--;
    check(req, "queued key code", q, e);
  endtask

  task automatic seg_scan(input string req, input bit rv, input int last, input logic [7:0] hi_mask);
    int bad = 0;
    int maxd = 0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 40; n++) begin
      int pos;
      pos = rv ? last - int'(digit_sel) : int'(digit_sel);
      if (int'(digit_sel) > maxd) maxd = int'(digit_sel);
      if (seg != ((8'h10 + 8'(pos)) & hi_mask)) bad++;
      @(negedge clk);
    end
    check(req, "highest digit position", maxd, last);
    check(req, "segment bytes mismatching", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected end of run");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [2:0] v;
    int waited;
    for (int r = 0; r < 8; r++) keymat[r] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check("R1", "irq after reset", irq, 0);
    check("R1", "scan_row after reset", scan_row, 0);
    check("R1", "digit_sel after reset", digit_sel, 0);
    check("R1", "seg after reset", seg, 0);
    rstat(q);
    check("R1", "status after reset", q, 8'h00);

    // R6 scan rate with P = 3
    cmd(8'h23);
    v = scan_row;
    waited = 0;
    while (scan_row == v && waited < 20) begin @(negedge clk); waited++; end
    v = scan_row;
    repeat (3) @(negedge clk);
    check("R6", "row held for P+1 cycles", scan_row, v);
    @(negedge clk);
    check("R6", "row step after P+1 cycles", scan_row, 3'(v + 3'd1));
    cmd(8'h20);
    cmd(8'hC3);

    // R2 single key
    press(3, 5);
    check("R5", "irq with a queued key", irq, 1);
    rstat(q);
    check("R11", "status count after one key", q[3:0], 1);
    take_one("R2");
    release_all();
    rstat(q);
    check("R2", "release queues nothing", q[3:0], 0);
    keymat[6][1] = 1'b1;
    repeat (4) @(negedge clk);
    keymat[6][1] = 1'b0;
    repeat (40) @(negedge clk);
    rstat(q);
    check("R2", "one-scan bounce queues nothing", q[3:0], 0);
    cmd(8'hE0);

    // R12 two new keys in one row, R5 hold behaviour
    keymat[2][6] = 1'b1;
    keymat[2][1] = 1'b1;
    exp_q.push_back(8'h11);
    exp_q.push_back(8'h16);
    model_cnt += 2;
    repeat (60) @(negedge clk);
    rstat(q);
    check("R12", "both same-row keys queued", q[3:0], 2);
    check("R5", "irq before read", irq, 1);
    take_one("R12");
    check("R5", "irq held after read", irq, 0);
    cmd(8'hE0);
    check("R5", "irq back after end-interrupt", irq, 1);
    take_one("R12");
    cmd(8'hE0);
    check("R5", "irq low with empty queue", irq, 0);
    release_all();

    // R4 underrun, R10 flag clear
    rdat(q);
    check("R4", "empty read data", q, 8'h00);
    rstat(q);
    check("R4", "underrun status", q, 8'h40);
    cmd(8'hC1);
    rstat(q);
    check("R10", "status after queue clear", q, 8'h00);

    // R3 overflow with nine keys
    for (int k = 0; k < 8; k++) press(k, k);
    press(0, 3);
    rstat(q);
    check("R3", "full queue with overrun", q, 8'h88);
    for (int k = 0; k < 8; k++) take_one("R3");
    check("R3", "expected codes left", exp_q.size(), 0);
    rstat(q);
    check("R3", "overrun sticky after drain", q, 8'hA0);
    release_all();
    cmd(8'hC1);
    rstat(q);
    check("R10", "flags cleared", q, 8'h00);

    // R7 keyboard off
    cmd(8'h01);
    keymat[4][2] = 1'b1;
    repeat (40) @(negedge clk);
    rstat(q);
    check("R7", "no code with keyboard off", q[3:0], 0);
    release_all();
    cmd(8'h00);
    rstat(q);
    check("R7", "no code after re-enable", q[3:0], 0);

    // R8 display memory access
    cmd(8'h90);
    for (int k = 0; k < 16; k++) wdat(8'h10 + 8'(k));
    cmd(8'h72);
    rdat(q); check("R8", "auto-increment read 2", q, 8'h12);
    rdat(q); check("R8", "auto-increment read 3", q, 8'h13);
    cmd(8'h65);
    rdat(q); check("R8", "fixed read 5 first", q, 8'h15);
    rdat(q); check("R8", "fixed read 5 again", q, 8'h15);

    // R7 digit count and order
    seg_scan("R7", 1'b0, 7, 8'hFF);
    cmd(8'h08);
    seg_scan("R7", 1'b0, 15, 8'hFF);
    cmd(8'h18);
    seg_scan("R7", 1'b1, 15, 8'hFF);
    cmd(8'h10);
    seg_scan("R7", 1'b1, 7, 8'hFF);
    cmd(8'h08);

    // R9 nibble inhibit and blanking
    cmd(8'hA8);
    cmd(8'h80);
    wdat(8'hAB);
    cmd(8'h60);
    rdat(q);
    check("R9", "upper nibble inhibited", q, 8'h1B);
    cmd(8'hA4);
    cmd(8'h80);
    wdat(8'hCD);
    rdat(q);
    check("R9", "lower nibble inhibited", q, 8'hCB);
    cmd(8'h80);
    cmd(8'hA0);
    wdat(8'h10);
    cmd(8'hA2);
    seg_scan("R9", 1'b0, 15, 8'h0F);
    cmd(8'hA0);

    // R10 display clear
    cmd(8'hC2);
    cmd(8'h65);
    rdat(q);
    check("R10", "display entry cleared", q, 8'h00);
    repeat (20) @(negedge clk);
    check("R10", "seg after display clear", seg, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule